// File: doc/BRIEF.md
# External/Status Change Interrupt Latch

This block watches the modem-control lines of one serial channel (clear-to-send, carrier detect and the sync/hunt line) together with three internal condition signals: transmit underrun, the baud-rate counter reaching zero, and the break/abort detector. Whenever an enabled source changes, it raises an interrupt request toward the host. At that moment it captures the current levels in a status snapshot.

The snapshot and the request then stay frozen, so the service routine reads one consistent picture. It stays frozen until the host pulses the clear command. After a clear, the block compares the live levels against the snapshot again. Anything that moved while the request was frozen raises a fresh request on the next cycle. The break/abort line is treated like the other levels, so both the start and the end of a sequence each produce their own interrupt.

The three modem lines are asynchronous. They pass through a two-stage synchronizer before comparison. The internal condition signals are already synchronous to `clk` and are used directly. There is no data stream, so every pin is a plain level or pulse.

Top module: `esl_extstat_latch`

## Requirements
- R1: After reset `irq` is 0 and `status` is all zeros.
- R2: A change in either direction on an enabled `cts_in` (status bit 0), `dcd_in` (bit 1) or `sync_in` (bit 2) sets `irq` after the third rising clock edge following the change, and not earlier. `status` then shows the new level on that bit.
- R3: `brk_abort` (status bit 3) raises `irq` one clock edge after it rises, when a sequence starts. It raises `irq` again one edge after it falls, when the sequence ends. Each time, `status` bit 3 shows the new level.
- R4: A change in either direction on `tx_underrun` (status bit 4) raises `irq` one edge later, with bit 4 showing the new level.
- R5: A one-cycle `brg_zero` pulse, when enabled, raises `irq` on the next edge and sets `status` bit 5.
- R6: A source whose `src_en` bit is 0 neither raises `irq` nor changes its `status` bit. Bit positions in `src_en` match those in `status`.
- R7: While `irq` is 1 and no clear is issued, `irq` stays 1 and `status` does not change, whatever the inputs do. A `brg_zero` pulse in this window is dropped.
- R8: A one-cycle `reset_cmd` drops `irq` on the following edge. It also clears `status` bit 5. Level bits 0 to 4 keep their snapshot.
- R9: On the first edge after a clear, any enabled level that differs from its snapshot raises `irq` again. The snapshot is reloaded with the live levels. Turning on an enable while the live level differs from the snapshot likewise raises `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| sync_in | input | 1 | Sync/hunt line, asynchronous |
| brk_abort | input | 1 | High while a break or abort sequence is being received |
| tx_underrun | input | 1 | Transmit underrun condition level |
| brg_zero | input | 1 | One-cycle pulse when the baud-rate counter reaches zero |
| src_en | input | 6 | Per-source enables, same bit order as `status` |
| reset_cmd | input | 1 | One-cycle clear command from the host |
| irq | output | 1 | External/status interrupt request |
| status | output | 6 | Frozen snapshot: {zero-count, underrun, break/abort, sync, dcd, cts} |

## Verification
The hardest case to reach is the re-raise. A source must move while the request is frozen, its snapshot must stay put, and the clear must then be followed at once by a second request that carries the new level. The stimulus opens a break sequence and lets the interrupt freeze. It then toggles underrun and fires a zero-count pulse inside the frozen window, and checks that neither one shows. Only then does it issue the clear. It expects `irq` low for exactly one cycle, then high again with underrun visible and the dropped zero-count pulse still absent. A second route re-enables a masked line whose level moved while it was disabled.

// File: rtl/esl_pkg.sv
package esl_pkg;
  localparam int NUM_LINES = 3;                  // asynchronous modem lines
  localparam int NUM_LEVEL = NUM_LINES + 2;      // plus break/abort and underrun
  localparam int NUM_SRC   = NUM_LEVEL + 1;      // plus zero-count event

  localparam int BIT_CTS  = 0;
  localparam int BIT_DCD  = 1;
  localparam int BIT_SYNC = 2;
  localparam int BIT_BRK  = 3;
  localparam int BIT_TXU  = 4;
  localparam int BIT_ZC   = 5;

  typedef logic [NUM_SRC-1:0]   src_vec_t;
  typedef logic [NUM_LEVEL-1:0] lvl_vec_t;
endpackage

// File: rtl/esl_sync.sv
module esl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)
        stage_q[s] <= '0;
      else if (s == 0)
        stage_q[s] <= async_in;
      else
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/esl_snapshot.sv
module esl_snapshot
  import esl_pkg::*;
#(
  parameter int NLVL = NUM_LEVEL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] live,
  input  logic [NLVL-1:0] lvl_en,
  input  logic            zc_pulse,
  input  logic            zc_en,
  input  logic            clr,
  output logic            pending,
  output logic [NLVL-1:0] snap,
  output logic            zc_flag
);
  logic [NLVL-1:0] moved;
  logic            zc_hit;
  logic            fire;

  assign moved  = (live ^ snap) & lvl_en;
  assign zc_hit = zc_pulse & zc_en;
  assign fire   = !pending && ((|moved) || zc_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      snap    <= '0;
      zc_flag <= 1'b0;
    end else if (clr) begin
      pending <= 1'b0;
      zc_flag <= 1'b0;
    end else if (fire) begin
      pending <= 1'b1;
      snap    <= (snap & ~lvl_en) | (live & lvl_en);
      zc_flag <= zc_flag | zc_hit;
    end
  end

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pending && !zc_flag);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> (pending && $stable(snap) && $stable(zc_flag)));

  assert_zc_with_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zc_flag) |-> pending);

  assert_reraise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !clr && ((live & lvl_en) != (snap & lvl_en))) |=>
      (pending && ((snap & $past(lvl_en)) == ($past(live) & $past(lvl_en)))));

  for (genvar i = 0; i < NLVL; i++) begin : g_mask_chk
    assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_en[i] |=> $stable(snap[i]));
  end
endmodule

// File: rtl/esl_extstat_latch.sv
module esl_extstat_latch
  import esl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cts_in,
  input  logic               dcd_in,
  input  logic               sync_in,
  input  logic               brk_abort,
  input  logic               tx_underrun,
  input  logic               brg_zero,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               reset_cmd,
  output logic               irq,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_LINES-1:0] lines_raw;
  logic [NUM_LINES-1:0] lines_sync;
  lvl_vec_t             live_lvl;
  lvl_vec_t             snap_lvl;
  logic                 zc_flag;

  assign lines_raw = {sync_in, dcd_in, cts_in};

  esl_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (lines_raw),
    .sync_out (lines_sync)
  );

  assign live_lvl = {tx_underrun, brk_abort, lines_sync};

  esl_snapshot #(
    .NLVL (NUM_LEVEL)
  ) u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (live_lvl),
    .lvl_en   (src_en[NUM_LEVEL-1:0]),
    .zc_pulse (brg_zero),
    .zc_en    (src_en[BIT_ZC]),
    .clr      (reset_cmd),
    .pending  (irq),
    .snap     (snap_lvl),
    .zc_flag  (zc_flag)
  );

  assign status = {zc_flag, snap_lvl};

  assert_status_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !$past(irq)) |-> (status[NUM_LEVEL-1:0] == $past(status[NUM_LEVEL-1:0])));
endmodule

// File: tb/esl_extstat_latch_test.sv
module esl_extstat_latch_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cts_in, dcd_in, sync_in;
  logic       brk_abort, tx_underrun, brg_zero;
  logic [5:0] src_en;
  logic       reset_cmd;
  logic       irq;
  logic [5:0] status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  esl_extstat_latch uut (
    .clk(clk), .rst_n(rst_n),
    .cts_in(cts_in), .dcd_in(dcd_in), .sync_in(sync_in),
    .brk_abort(brk_abort), .tx_underrun(tx_underrun), .brg_zero(brg_zero),
    .src_en(src_en), .reset_cmd(reset_cmd),
    .irq(irq), .status(status)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic expect_out(input string req, input logic exp_irq, input logic [5:0] exp_st);
    n_checks++;
    if (irq !== exp_irq || status !== exp_st) begin
      n_fail++;
      $display("FAIL %s: irq=%0b status=%06b, expected irq=%0b status=%06b",
               req, irq, status, exp_irq, exp_st);
    end
  endtask

  task automatic clear_pulse;
    reset_cmd = 1'b1;
    step(1);
    reset_cmd = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cts_in = 0; dcd_in = 0; sync_in = 0;
    brk_abort = 0; tx_underrun = 0; brg_zero = 0;
    src_en = 6'b111111; reset_cmd = 0;
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_out("R1 reset state", 1'b0, 6'b000000);
  endtask

  task automatic t_modem_lines;
    cts_in = 1'b1;
    step(2);
    expect_out("R2 cts no early irq", 1'b0, 6'b000000);
    step(1);
    expect_out("R2 cts rise", 1'b1, 6'b000001);
    clear_pulse();
    expect_out("R8 clear drops irq", 1'b0, 6'b000001);
    step(1);
    expect_out("R8 no change stays quiet", 1'b0, 6'b000001);
    cts_in = 1'b0;
    step(3);
    expect_out("R2 cts fall", 1'b1, 6'b000000);
    clear_pulse();
    dcd_in = 1'b1;
    step(3);
    expect_out("R2 dcd rise", 1'b1, 6'b000010);
    clear_pulse();
    sync_in = 1'b1;
    step(3);
    expect_out("R2 sync rise", 1'b1, 6'b000110);
    clear_pulse();
    dcd_in = 1'b0; sync_in = 1'b0;
    step(3);
    expect_out("R2 dcd+sync fall", 1'b1, 6'b000000);
    clear_pulse();
    step(1);
  endtask

  task automatic t_break;
    brk_abort = 1'b1;
    step(1);
    expect_out("R3 break start", 1'b1, 6'b001000);
    clear_pulse();
    brk_abort = 1'b0;
    step(1);
    expect_out("R3 break end", 1'b1, 6'b000000);
    clear_pulse();
    step(1);
  endtask

  task automatic t_underrun_zero;
    tx_underrun = 1'b1;
    step(1);
    expect_out("R4 underrun rise", 1'b1, 6'b010000);
    clear_pulse();
    tx_underrun = 1'b0;
    step(1);
    expect_out("R4 underrun fall", 1'b1, 6'b000000);
    clear_pulse();
    brg_zero = 1'b1;
    step(1);
    brg_zero = 1'b0;
    expect_out("R5 zero count", 1'b1, 6'b100000);
    clear_pulse();
    expect_out("R8 zero flag cleared", 1'b0, 6'b000000);
    step(1);
  endtask

  task automatic t_masked;
    src_en = 6'b111110;
    cts_in = 1'b1;
    step(4);
    expect_out("R6 masked cts", 1'b0, 6'b000000);
    src_en = 6'b011110;
    brg_zero = 1'b1;
    step(1);
    brg_zero = 1'b0;
    expect_out("R6 masked zero count", 1'b0, 6'b000000);
    src_en = 6'b111111;
    step(1);
    expect_out("R9 enable exposes moved cts", 1'b1, 6'b000001);
    clear_pulse();
    cts_in = 1'b0;
    step(3);
    expect_out("R2 cts back low", 1'b1, 6'b000000);
    clear_pulse();
    step(1);
  endtask

  task automatic t_freeze_reraise;
    brk_abort = 1'b1;
    step(1);
    expect_out("R3 break start again", 1'b1, 6'b001000);
    tx_underrun = 1'b1;
    step(2);
    expect_out("R7 frozen on underrun", 1'b1, 6'b001000);
    brg_zero = 1'b1;
    step(1);
    brg_zero = 1'b0;
    expect_out("R7 zero pulse dropped", 1'b1, 6'b001000);
    clear_pulse();
    expect_out("R8 gap after clear", 1'b0, 6'b001000);
    step(1);
    expect_out("R9 re-raise with underrun", 1'b1, 6'b011000);
    clear_pulse();
    brk_abort = 1'b0; tx_underrun = 1'b0;
    step(1);
    expect_out("R9 both fall", 1'b1, 6'b000000);
    clear_pulse();
    step(1);
    expect_out("R8 idle at end", 1'b0, 6'b000000);
  endtask

  initial begin
    t_reset();
    t_modem_lines();
    t_break();
    t_underrun_zero();
    t_masked();
    t_freeze_reraise();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule